// File: doc/BRIEF.md
# Interrupt Redirection and Message Delivery Engine

This block sits between a bank of interrupt input pins and the memory-write path of a processor complex. It keeps one redirection entry per table slot: vector, delivery mode, destination mode, trigger mode, mask and a 16-bit destination. It also keeps two per-entry flags: a pending request bit (IRR) and an in-service bit (remote-IRR). Each unmasked pending request becomes one 32-bit memory-write message, an address and a data word, offered on a valid/ready port one message at a time.

Edge-triggered entries latch a rising input and forget it once delivered. Level-triggered entries follow the input level. Once delivered, a level entry is held in service, so further requests from it are coalesced until an end-of-interrupt (EOI) arrives carrying the same vector. That EOI releases every matching entry, and any still-pending unmasked request is then delivered again. Configuration reaches the table through a plain write port with separate strobes for the control fields and the destination field.

Top module: `irq_route_engine`

## Requirements
- R1: Input pin 0 drives entry 2. Pin k, for 1 <= k < NUM_ENTRIES, drives entry k. Entry 0 has no pin, and pins at or above NUM_ENTRIES have no effect.
- R2: On a level entry, a rising input sets IRR and a falling input clears it. A request whose input falls before it is delivered is never delivered.
- R3: On an edge entry, a rising input is discarded when the entry is masked, so unmasking later produces no message.
- R4: On an unmasked edge entry, a rising input produces exactly one message, and delivery clears that entry's IRR.
- R5: A service pass delivers eligible entries in increasing index order.
- R6: Delivering a level entry sets its remote-IRR. While remote-IRR is set, no further message is sent for that entry.
- R7: An EOI with vector V clears remote-IRR on every entry whose remote-IRR is set and whose vector equals V. A matching entry that is unmasked with IRR still set is delivered again. An EOI with any other vector has no effect.
- R8: The message address is 0xFEE00000 OR (destination << 4) OR (destination mode << 2). The message data is vector in bits [7:0], delivery mode in bits [10:8] and trigger mode in bit 15 (1 = level).
- R9: A message stays valid, with address and data unchanged, until it is accepted. A new message is never started while one is still outstanding.
- R10: A pulse on `tbl_we_cfg` loads `tbl_cfg` into entry `tbl_idx` with this packing: vector [7:0], delivery mode [10:8], destination mode [11], trigger [12] (1 = level), mask [13]. A pulse on `tbl_we_dest` loads the destination. Remote-IRR has no write path, and an entry set to edge trigger has its remote-IRR cleared. Every write starts a service pass.
- R11: After reset every entry is masked and edge-triggered with all other fields zero, IRR and remote-IRR are clear, and `msg_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Interrupt input levels |
| tbl_we_cfg | input | 1 | Write strobe for the control fields of entry `tbl_idx` |
| tbl_we_dest | input | 1 | Write strobe for the destination field of entry `tbl_idx` |
| tbl_idx | input | IDX_W | Entry index for table writes |
| tbl_cfg | input | 14 | Packed control fields (see R10) |
| tbl_dest | input | 16 | Destination field |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high together with `msg_valid` |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the engine with NUM_ENTRIES = 8 and NUM_PINS = 12. With these values the pins above the table (8 to 11) can be driven, so the ignored-pin rule and the pin 0 to entry 2 remap are both reachable. Passes are also short, which makes the ordering of two entries raised in the same cycle easy to observe. The eight-entry table still covers edge, level, masked and in-service combinations, EOI matching against several vectors, and the sequence that toggles an entry between trigger modes to release its in-service flag.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int VEC_W  = 8;
  localparam int DLV_W  = 3;
  localparam int DEST_W = 16;
  localparam int CFG_W  = VEC_W + DLV_W + 3;

  typedef struct packed {
    logic             mask;
    logic             level;
    logic             dmode;
    logic [DLV_W-1:0] dlv;
    logic [VEC_W-1:0] vec;
  } rte_cfg_t;

  typedef struct packed {
    rte_cfg_t          cfg;
    logic [DEST_W-1:0] dest;
  } rte_t;

  localparam rte_t RTE_RESET = '{cfg: '{mask: 1'b1, level: 1'b0, dmode: 1'b0,
                                        dlv: '0, vec: '0},
                                 dest: '0};

  function automatic logic [31:0] msg_addr_of(input rte_t r, input logic [31:0] base);
    return base | (32'(r.dest) << 4) | (32'(r.cfg.dmode) << 2);
  endfunction

  function automatic logic [31:0] msg_data_of(input rte_t r);
    return 32'(r.cfg.vec) | (32'(r.cfg.dlv) << 8) | (32'(r.cfg.level) << 15);
  endfunction

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
  parameter int NUM_ENTRIES = 24,
  parameter int NUM_PINS    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS-1:0]    pin_in,
  output logic [NUM_ENTRIES-1:0] rise,
  output logic [NUM_ENTRIES-1:0] fall
);

  logic [NUM_ENTRIES-1:0] ent_now;
  logic [NUM_ENTRIES-1:0] ent_q;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_map
    if (e == 0) begin : g_none
      assign ent_now[e] = 1'b0;
    end else if (e == 2) begin : g_remap
      assign ent_now[e] = pin_in[0] | pin_in[2];
    end else if (e < NUM_PINS) begin : g_direct
      assign ent_now[e] = pin_in[e];
    end else begin : g_absent
      assign ent_now[e] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    ent_q <= ent_now;
  end

  assign rise = ent_now & ~ent_q;
  assign fall = ~ent_now & ent_q;

  if (NUM_PINS > NUM_ENTRIES) begin : g_upper
    // R1: activity on pins above the table never reaches an entry
    p_upper_pins_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(pin_in[NUM_PINS-1:NUM_ENTRIES]) && $stable(pin_in[NUM_ENTRIES-1:0]))
        |-> (rise == '0 && fall == '0));
  end

endmodule

// File: rtl/irq_rte_table.sv
module irq_rte_table
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_cfg,
  input  logic                        we_dest,
  input  logic [IDX_W-1:0]            idx,
  input  rte_cfg_t                    cfg,
  input  logic [DEST_W-1:0]           dest,
  output rte_t [NUM_ENTRIES-1:0]      entries
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) entries[e] <= RTE_RESET;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (we_cfg && idx == IDX_W'(e))  entries[e].cfg  <= cfg;
        if (we_dest && idx == IDX_W'(e)) entries[e].dest <= dest;
      end
    end
  end

  // R10: a control write lands in the addressed entry on the next cycle
  p_cfg_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_cfg && int'(idx) < NUM_ENTRIES) |=> entries[$past(idx)].cfg == $past(cfg));

endmodule

// File: rtl/irq_pend_state.sv
module irq_pend_state
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rte_t [NUM_ENTRIES-1:0] entries,
  input  logic [NUM_ENTRIES-1:0] rise,
  input  logic [NUM_ENTRIES-1:0] fall,
  input  logic                   issue,
  input  logic [IDX_W-1:0]       issue_idx,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic [NUM_ENTRIES-1:0] elig,
  output logic                   eoi_retrig
);

  logic [NUM_ENTRIES-1:0] irr, irr_n;
  logic [NUM_ENTRIES-1:0] remote, remote_n;
  logic [NUM_ENTRIES-1:0] eoi_hit;
  logic [NUM_ENTRIES-1:0] iss_vec;

  always_comb begin
    irr_n      = irr;
    remote_n   = remote;
    eoi_retrig = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      iss_vec[e] = issue && (issue_idx == IDX_W'(e));
      eoi_hit[e] = eoi_valid && remote[e] && (entries[e].cfg.vec == eoi_vector);
      if (entries[e].cfg.level) begin
        if (rise[e])    irr_n[e]    = 1'b1;
        if (fall[e])    irr_n[e]    = 1'b0;
        if (iss_vec[e]) remote_n[e] = 1'b1;
        if (eoi_hit[e]) remote_n[e] = 1'b0;
      end else begin
        if (iss_vec[e])                        irr_n[e] = 1'b0;
        if (rise[e] && !entries[e].cfg.mask)   irr_n[e] = 1'b1;
        remote_n[e] = 1'b0;
      end
      elig[e] = irr[e] && !entries[e].cfg.mask && !(entries[e].cfg.level && remote[e]);
      if (eoi_hit[e] && irr[e] && !entries[e].cfg.mask) eoi_retrig = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr    <= '0;
      remote <= '0;
    end else begin
      irr    <= irr_n;
      remote <= remote_n;
    end
  end

  // R6: delivering a level entry places it in service
  p_level_issue_sets_remote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && entries[issue_idx].cfg.level) |=> remote[$past(issue_idx)]);

  // R4: delivering an edge entry consumes its request
  p_edge_issue_clears_irr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !entries[issue_idx].cfg.level && !rise[issue_idx]) |=> !irr[$past(issue_idx)]);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_eoi_chk
    // R7: a matching EOI releases the entry
    p_eoi_clears_remote_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && remote[e] && entries[e].cfg.vec == eoi_vector) |=> !remote[e]);
  end

endmodule

// File: rtl/irq_scan_ctl.sv
module irq_scan_ctl
  import irq_route_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [31:0] MSG_BASE    = 32'hFEE0_0000,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rte_t [NUM_ENTRIES-1:0] entries,
  input  logic [NUM_ENTRIES-1:0] elig,
  input  logic                   pass_trig,
  output logic                   issue,
  output logic [IDX_W-1:0]       issue_idx,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [31:0]            msg_addr,
  output logic [31:0]            msg_data
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SEND} scan_st_t;

  scan_st_t         state;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] cur_idx;
  logic             pend;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  // lowest eligible entry at or above the scan pointer
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (elig[e] && (e >= int'(ptr))) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(e);
      end
    end
  end

  assign issue     = (state == S_SCAN) && hit;
  assign issue_idx = hit_idx;
  assign msg_valid = (state == S_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      cur_idx  <= '0;
      pend     <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (pend) begin
            state <= S_SCAN;
            ptr   <= '0;
            pend  <= pass_trig;
          end else begin
            pend  <= pass_trig;
          end
        end
        S_SCAN: begin
          pend <= pend | pass_trig;
          if (hit) begin
            cur_idx  <= hit_idx;
            msg_addr <= msg_addr_of(entries[hit_idx], MSG_BASE);
            msg_data <= msg_data_of(entries[hit_idx]);
            state    <= S_SEND;
          end else begin
            state <= S_IDLE;
          end
        end
        default: begin
          pend <= pend | pass_trig;
          if (msg_ready) begin
            if (cur_idx == IDX_W'(NUM_ENTRIES - 1)) begin
              state <= S_IDLE;
            end else begin
              ptr   <= cur_idx + 1'b1;
              state <= S_SCAN;
            end
          end
        end
      endcase
    end
  end

  // R9: an offered message is held unchanged until taken
  p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R9: no new delivery while a message is outstanding
  p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !msg_valid);

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter int          NUM_PINS    = 32,
  parameter logic [31:0] MSG_BASE    = 32'hFEE0_0000,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                tbl_we_cfg,
  input  logic                tbl_we_dest,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic [CFG_W-1:0]    tbl_cfg,
  input  logic [DEST_W-1:0]   tbl_dest,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data
);

  rte_t [NUM_ENTRIES-1:0] entries;
  logic [NUM_ENTRIES-1:0] rise, fall, elig;
  logic                   eoi_retrig;
  logic                   issue;
  logic [IDX_W-1:0]       issue_idx;
  logic                   pass_trig;

  irq_pin_front #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PINS(NUM_PINS)) u_front (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall));

  irq_rte_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .we_cfg(tbl_we_cfg), .we_dest(tbl_we_dest),
    .idx(tbl_idx), .cfg(rte_cfg_t'(tbl_cfg)), .dest(tbl_dest), .entries(entries));

  irq_pend_state #(.NUM_ENTRIES(NUM_ENTRIES)) u_pend (
    .clk(clk), .rst_n(rst_n), .entries(entries), .rise(rise), .fall(fall),
    .issue(issue), .issue_idx(issue_idx), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .elig(elig), .eoi_retrig(eoi_retrig));

  assign pass_trig = (|rise) | tbl_we_cfg | tbl_we_dest | eoi_retrig;

  irq_scan_ctl #(.NUM_ENTRIES(NUM_ENTRIES), .MSG_BASE(MSG_BASE)) u_scan (
    .clk(clk), .rst_n(rst_n), .entries(entries), .elig(elig),
    .pass_trig(pass_trig), .issue(issue), .issue_idx(issue_idx),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  // R3: a masked entry is never delivered
  p_issue_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !entries[issue_idx].cfg.mask);

endmodule

// File: tb/irq_route_engine_test.sv
module irq_route_engine_test;

  localparam int N     = 8;
  localparam int P     = 12;
  localparam int IW    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [P-1:0] pins = '0;
  logic        we_cfg = 1'b0, we_dest = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [13:0] cfg = '0;
  logic [15:0] dest = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_route_engine #(.NUM_ENTRIES(N), .NUM_PINS(P)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .tbl_we_cfg(we_cfg),
    .tbl_we_dest(we_dest), .tbl_idx(idx), .tbl_cfg(cfg), .tbl_dest(dest),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  // idx(3) vec(8) dlv(3) dmode(1) dest(16)
  localparam logic [30:0] VECS [5] = '{
    {3'd1, 8'h31, 3'd0, 1'b0, 16'h0001},
    {3'd2, 8'h92, 3'd1, 1'b1, 16'hA5C3},
    {3'd3, 8'h13, 3'd4, 1'b0, 16'h00FF},
    {3'd7, 8'hF7, 3'd7, 1'b1, 16'hFFFF},
    {3'd4, 8'h04, 3'd2, 1'b1, 16'h8000}
  };

  function automatic logic [31:0] exp_addr(input logic [15:0] d, input logic dm);
    return 32'hFEE0_0000 + {12'h000, d, 4'h0} + (dm ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] exp_data(input logic [7:0] v, input logic [2:0] dl,
                                           input logic lvl);
    return {16'h0000, lvl, 4'h0, dl, v};
  endfunction

  task automatic write_entry(input int i, input logic msk, input logic lvl,
                             input logic dm, input logic [2:0] dl, input logic [7:0] v,
                             input logic [15:0] d);
    @(negedge clk);
    idx = IW'(i); cfg = {msk, lvl, dm, dl, v}; dest = d; we_cfg = 1'b1; we_dest = 1'b1;
    @(negedge clk);
    we_cfg = 1'b0; we_dest = 1'b0;
  endtask

  task automatic write_cfg(input int i, input logic msk, input logic lvl,
                           input logic dm, input logic [2:0] dl, input logic [7:0] v);
    @(negedge clk);
    idx = IW'(i); cfg = {msk, lvl, dm, dl, v}; we_cfg = 1'b1;
    @(negedge clk);
    we_cfg = 1'b0;
  endtask

  task automatic pin_pulse(input int p);
    @(negedge clk); pins[p] = 1'b1;
    repeat (2) @(negedge clk);
    pins[p] = 1'b0;
    @(negedge clk);
  endtask

  task automatic pin_set(input int p, input logic v);
    @(negedge clk); pins[p] = v;
    @(negedge clk);
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic expect_msg(input logic [31:0] ea, input logic [31:0] ed, input string tag);
    int n = 0;
    while (!msg_valid && n < 100) begin @(negedge clk); n++; end
    checks++;
    if (!msg_valid || msg_addr !== ea || msg_data !== ed) begin
      fails++;
      $display("FAIL %s: valid=%0b addr=%h data=%h, expected addr=%h data=%h",
               tag, msg_valid, msg_addr, msg_data, ea, ed);
    end
    if (msg_valid) begin
      msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input string tag);
    bit seen = 1'b0;
    repeat (40) begin @(negedge clk); if (msg_valid) seen = 1'b1; end
    checks++;
    if (seen) begin
      fails++;
      $display("FAIL %s: message addr=%h data=%h seen, expected none", tag, msg_addr, msg_data);
      while (msg_valid) begin msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: idle after reset, and reset entries are masked
    checks++;
    if (msg_valid !== 1'b0) begin
      fails++; $display("FAIL R11: msg_valid=%0b expected 0", msg_valid);
    end
    pin_pulse(3);
    expect_none("R11 reset entry masked");

    // R8 / R4: encoding across a table of entry settings
    for (int i = 0; i < 5; i++) begin
      logic [30:0] t;
      t = VECS[i];
      write_entry(int'(t[30:28]), 1'b0, 1'b0, t[16], t[19:17], t[27:20], t[15:0]);
      pin_pulse(int'(t[30:28]));
      expect_msg(exp_addr(t[15:0], t[16]), exp_data(t[27:20], t[19:17], 1'b0), "R8 encoding");
    end
    expect_none("R4 single message per edge");

    // R1: pin 0 drives entry 2, pins past the table are dead
    write_entry(2, 1'b0, 1'b0, 1'b0, 3'd0, 8'h22, 16'h0002);
    pin_pulse(0);
    expect_msg(exp_addr(16'h0002, 1'b0), exp_data(8'h22, 3'd0, 1'b0), "R1 pin0 to entry2");
    pin_pulse(10);
    pin_pulse(8);
    expect_none("R1 pins above table ignored");

    // R3: masked edge request discarded
    write_entry(4, 1'b1, 1'b0, 1'b0, 3'd0, 8'h44, 16'h0004);
    pin_pulse(4);
    write_cfg(4, 1'b0, 1'b0, 1'b0, 3'd0, 8'h44);
    expect_none("R3 masked edge ignored");

    // R5: two entries raised together go out lowest first
    write_entry(6, 1'b0, 1'b0, 1'b0, 3'd0, 8'h66, 16'h0006);
    write_entry(5, 1'b0, 1'b0, 1'b0, 3'd0, 8'h55, 16'h0005);
    @(negedge clk); pins[5] = 1'b1; pins[6] = 1'b1;
    repeat (2) @(negedge clk); pins[5] = 1'b0; pins[6] = 1'b0;
    expect_msg(exp_addr(16'h0005, 1'b0), exp_data(8'h55, 3'd0, 1'b0), "R5 first lower index");
    expect_msg(exp_addr(16'h0006, 1'b0), exp_data(8'h66, 3'd0, 1'b0), "R5 second higher index");

    // R6 / R7 / R2: level entry coalescing and EOI release
    write_entry(3, 1'b0, 1'b1, 1'b0, 3'd1, 8'h40, 16'h0003);
    pin_set(3, 1'b1);
    expect_msg(exp_addr(16'h0003, 1'b0), exp_data(8'h40, 3'd1, 1'b1), "R6 level delivered");
    pin_set(3, 1'b0);
    pin_set(3, 1'b1);
    expect_none("R6 in-service level suppressed");
    send_eoi(8'h41);
    expect_none("R7 non-matching EOI has no effect");
    send_eoi(8'h40);
    expect_msg(exp_addr(16'h0003, 1'b0), exp_data(8'h40, 3'd1, 1'b1), "R7 EOI redelivers");
    pin_set(3, 1'b0);
    send_eoi(8'h40);
    expect_none("R2 fallen level not redelivered");

    // R2: masked level request that falls before unmask is lost
    write_entry(7, 1'b1, 1'b1, 1'b0, 3'd0, 8'h77, 16'h0007);
    pin_set(7, 1'b1);
    pin_set(7, 1'b0);
    write_cfg(7, 1'b0, 1'b1, 1'b0, 3'd0, 8'h77);
    expect_none("R2 level dropped while masked");

    // R9: hold while not ready
    pin_pulse(1);
    begin
      int n = 0;
      logic [31:0] a0, d0;
      bit bad = 1'b0;
      while (!msg_valid && n < 100) begin @(negedge clk); n++; end
      a0 = msg_addr; d0 = msg_data;
      repeat (6) begin
        @(negedge clk);
        if (!msg_valid || msg_addr !== a0 || msg_data !== d0) bad = 1'b1;
      end
      checks++;
      if (bad || a0 !== exp_addr(16'h0001, 1'b0)) begin
        fails++;
        $display("FAIL R9: addr=%h valid=%0b, expected held addr=%h", msg_addr, msg_valid,
                 exp_addr(16'h0001, 1'b0));
      end
      msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    end
    expect_none("R9 single message after hold");

    // R10: edge rewrite releases in-service flag, dest write takes effect
    pin_set(3, 1'b1);
    expect_msg(exp_addr(16'h0003, 1'b0), exp_data(8'h40, 3'd1, 1'b1), "R10 level in service");
    write_cfg(3, 1'b1, 1'b0, 1'b0, 3'd1, 8'h40);
    write_cfg(3, 1'b1, 1'b1, 1'b0, 3'd1, 8'h40);
    @(negedge clk); idx = IW'(3); dest = 16'h0BEE; we_dest = 1'b1;
    @(negedge clk); we_dest = 1'b0;
    write_cfg(3, 1'b0, 1'b1, 1'b1, 3'd1, 8'h40);
    expect_msg(exp_addr(16'h0BEE, 1'b1), exp_data(8'h40, 3'd1, 1'b1), "R10 mode toggle release");
    pin_set(3, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule